// File: doc/BRIEF.md
# Multi-Channel Event Timer

The block has a single free-running main counter and a parameterised set of comparator channels. Software reaches them through a word-addressed 32-bit register bus. Each channel watches the counter for a programmed compare value. On a match it can do one of three things: pulse or hold a general interrupt line, drive one of two fixed legacy lines, or issue a message write that carries a data word and an address. The channel to use for the periodic system tick is typically programmed once in periodic mode and then left to run. Other channels are reprogrammed in one-shot mode for each deadline.

The counter is 64 bits wide. It is read as two words, and reading the low word freezes a copy of the high word, so a wrap between the two reads cannot tear the value. A periodic channel uses a set-value handshake. The comparator write made while set-value is armed loads the compare value. The write after it loads the reload period, which is added to the compare value on every match.

Top module: `evt_timer`

## Requirements
- R1: Word 0 reads the channel count minus one in bits [7:0] and a legacy-routing-capable flag in bit 15. Word 1 reads the tick length in femtoseconds (parameter `TICK_FS`). Both ignore writes.
- R2: The counter advances by one per cycle only while general-config (word 2) bit 0 is set. Writes to the low word (word 4) and high word (word 5) take effect only while the counter is stopped, and are ignored while it runs.
- R3: A read of word 4 latches the high half of the counter. A later read of word 5 returns that latched half, even if the counter has carried into its high half in between.
- R4: An enabled one-shot channel (config bit 0) fires when the counter equals its compare value. Its output appears two cycles after the cycle in which the counter holds that value, and the channel does not fire again unless the counter wraps. A channel with bit 0 clear never fires.
- R5: For a channel with periodic (bit 1) and set-value (bit 2) set, a comparator write loads the compare value and clears set-value. Set-value clears on the low-word write in 32-bit mode (bit 3) and on the high-word write otherwise. A read of the comparator on the next bus access returns the value just written.
- R6: After the handshake, further comparator writes load the period, and each match adds the period to the compare value. A periodic channel therefore fires every period cycles.
- R7: While general-config bit 1 is set, channel 0 drives `legacy_tick` and channel 1 drives `legacy_rtc`, and neither drives `irq_out`, whatever its route field holds. While the bit is clear, both legacy lines stay low.
- R8: An edge-mode channel (config bit 4 clear) produces a single one-cycle pulse on `irq_out[route]`, where route is config bits [12:8].
- R9: A level-mode channel (bit 4 set) sets its bit in the status word (word 3) on a match. It holds `irq_out[route]` high until software writes 1 to that status bit. Writing 0 has no effect.
- R10: A channel with message routing (bit 5) does not drive `irq_out`. Instead, its match raises `msg_valid` for one cycle with its route-data word (channel word 4) and route-address word (channel word 5). When several channels match in the same cycle, the lowest-numbered one is issued.
- R11: In 32-bit mode only the low 32 bits of counter and compare value are matched. In 64-bit mode all 64 bits must be equal.

Channel i occupies words 8(i+1) onward: +0 config (bits 14 and 15 read as message-capable and periodic-capable), +2/+3 comparator low/high, +4 route data, +5 route address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data valid the next cycle |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | NLINES | General interrupt lines |
| legacy_tick | output | 1 | Legacy tick line (channel 0 in legacy mode) |
| legacy_rtc | output | 1 | Legacy RTC line (channel 1 in legacy mode) |
| msg_valid | output | 1 | One-cycle message write request |
| msg_data | output | 32 | Message data word |
| msg_addr | output | 32 | Message address |

## Verification
The hardest case to reach from the ports is a torn counter read. It needs the low half to carry into the high half between the two word reads. The bench loads the counter, while it is stopped, with a value a few ticks short of the carry, starts it, reads the low word at once, and reads the high word only after the carry. This distinguishes the latched half from the live half. The 32-bit mode case uses the same preloading: the high half is set non-zero, so a full 64-bit match on another channel can never occur while the low-word match does.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int DW = 32;
  localparam int CW = 2 * DW;

  // word index inside the global region
  localparam logic [2:0] W_CAP  = 3'd0;
  localparam logic [2:0] W_PRD  = 3'd1;
  localparam logic [2:0] W_GCFG = 3'd2;
  localparam logic [2:0] W_STS  = 3'd3;
  localparam logic [2:0] W_CNTL = 3'd4;
  localparam logic [2:0] W_CNTH = 3'd5;

  // word index inside a channel region
  localparam logic [2:0] W_CFG  = 3'd0;
  localparam logic [2:0] W_CMPL = 3'd2;
  localparam logic [2:0] W_CMPH = 3'd3;
  localparam logic [2:0] W_RTD  = 3'd4;
  localparam logic [2:0] W_RTA  = 3'd5;

  // channel config bits
  localparam int B_EN     = 0;
  localparam int B_PER    = 1;
  localparam int B_SETV   = 2;
  localparam int B_M32    = 3;
  localparam int B_LVL    = 4;
  localparam int B_MSG    = 5;
  localparam int B_ROUTE  = 8;
  localparam int B_MSGCAP = 14;
  localparam int B_PERCAP = 15;

  // global config / capability bits
  localparam int G_RUN   = 0;
  localparam int G_LEG   = 1;
  localparam int CAP_LEG = 15;
endpackage

// File: rtl/evt_counter.sv
module evt_counter
  import evt_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic          rd_lo,
  input  logic [DW-1:0] wdata,
  output logic [CW-1:0] cnt,
  output logic [DW-1:0] snap_hi
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      snap_hi <= '0;
    end else begin
      if (run)        cnt          <= cnt + 1'b1;
      else if (wr_lo) cnt[DW-1:0]  <= wdata;
      else if (wr_hi) cnt[CW-1:DW] <= wdata;
      if (rd_lo) snap_hi <= cnt[CW-1:DW];
    end
  end
endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_pkg::*;
#(
  parameter int   LINE_W  = 2,
  parameter logic PER_CAP = 1'b1,
  parameter logic MSG_CAP = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW-1:0]     cnt,
  input  logic              run,
  input  logic              wr,
  input  logic [2:0]        woff,
  input  logic [DW-1:0]     wdata,
  input  logic              sts_clr,
  input  logic [2:0]        roff,
  output logic [DW-1:0]     rdata,
  output logic              lvl,
  output logic              msg_en,
  output logic [LINE_W-1:0] route,
  output logic [DW-1:0]     rt_data,
  output logic [DW-1:0]     rt_addr,
  output logic              fire,
  output logic              sts
);
  logic          en, per, setv, m32;
  logic [CW-1:0] cmp, prd;
  logic          eq, hit, load_cmp;

  always_comb begin
    eq       = m32 ? (cnt[DW-1:0] == cmp[DW-1:0]) : (cnt == cmp);
    hit      = en && run && eq;
    load_cmp = !per || setv;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {en, per, setv, m32, lvl, msg_en} <= '0;
      route   <= '0;
      cmp     <= '0;
      prd     <= '0;
      rt_data <= '0;
      rt_addr <= '0;
      fire    <= 1'b0;
      sts     <= 1'b0;
    end else begin
      fire <= hit;
      if (hit && lvl)   sts <= 1'b1;
      else if (sts_clr) sts <= 1'b0;
      if (hit && per)
        cmp <= m32 ? {{DW{1'b0}}, cmp[DW-1:0] + prd[DW-1:0]} : cmp + prd;
      if (wr) begin
        case (woff)
          W_CFG: begin
            en     <= wdata[B_EN];
            per    <= PER_CAP & wdata[B_PER];
            setv   <= wdata[B_SETV];
            m32    <= wdata[B_M32];
            lvl    <= wdata[B_LVL];
            msg_en <= MSG_CAP & wdata[B_MSG];
            route  <= wdata[B_ROUTE +: LINE_W];
          end
          W_CMPL: begin
            if (load_cmp) begin
              cmp[DW-1:0] <= wdata;
              if (m32) setv <= 1'b0;
            end else prd[DW-1:0] <= wdata;
          end
          W_CMPH: begin
            if (load_cmp) begin
              cmp[CW-1:DW] <= wdata;
              if (!m32) setv <= 1'b0;
            end else prd[CW-1:DW] <= wdata;
          end
          W_RTD:   rt_data <= wdata;
          W_RTA:   rt_addr <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (roff)
      W_CFG: begin
        rdata[B_EN]     = en;
        rdata[B_PER]    = per;
        rdata[B_SETV]   = setv;
        rdata[B_M32]    = m32;
        rdata[B_LVL]    = lvl;
        rdata[B_MSG]    = msg_en;
        rdata[B_ROUTE +: LINE_W] = route;
        rdata[B_MSGCAP] = MSG_CAP;
        rdata[B_PERCAP] = PER_CAP;
      end
      W_CMPL:  rdata = cmp[DW-1:0];
      W_CMPH:  rdata = cmp[CW-1:DW];
      W_RTD:   rdata = rt_data;
      W_RTA:   rdata = rt_addr;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_pkg::*;
#(
  parameter int              NCH          = 3,
  parameter int              NLINES       = 4,
  parameter int              ADDR_W       = 6,
  parameter logic [DW-1:0]   TICK_FS      = 32'd69841279,
  parameter logic [NCH-1:0]  PER_CAP_MASK = '1,
  parameter logic [NCH-1:0]  MSG_CAP_MASK = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NLINES-1:0] irq_out,
  output logic              legacy_tick,
  output logic              legacy_rtc,
  output logic              msg_valid,
  output logic [DW-1:0]     msg_data,
  output logic [DW-1:0]     msg_addr
);
  localparam int LINE_W = (NLINES > 1) ? $clog2(NLINES) : 1;
  localparam int RGN_W  = ADDR_W - 3;

  logic [RGN_W-1:0] rgn;
  logic [2:0]       widx;
  logic             top_sel;
  logic             run, leg;
  logic [CW-1:0]    cnt;
  logic [DW-1:0]    snap_hi;

  logic [NCH-1:0]    ch_lvl, ch_msg, ch_fire, ch_sts;
  logic [LINE_W-1:0] ch_route [NCH];
  logic [DW-1:0]     ch_rdata [NCH];
  logic [DW-1:0]     ch_rtd   [NCH];
  logic [DW-1:0]     ch_rta   [NCH];

  assign rgn     = bus_addr[ADDR_W-1:3];
  assign widx    = bus_addr[2:0];
  assign top_sel = (rgn == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      leg <= 1'b0;
    end else if (bus_wr && top_sel && widx == W_GCFG) begin
      run <= bus_wdata[G_RUN];
      leg <= (NCH > 1) && bus_wdata[G_LEG];
    end
  end

  evt_counter i_counter (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .wr_lo   (bus_wr && top_sel && widx == W_CNTL),
    .wr_hi   (bus_wr && top_sel && widx == W_CNTH),
    .rd_lo   (bus_rd && top_sel && widx == W_CNTL),
    .wdata   (bus_wdata),
    .cnt     (cnt),
    .snap_hi (snap_hi)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    evt_channel #(
      .LINE_W  (LINE_W),
      .PER_CAP (PER_CAP_MASK[i]),
      .MSG_CAP (MSG_CAP_MASK[i])
    ) i_channel (
      .clk     (clk),
      .rst     (rst),
      .cnt     (cnt),
      .run     (run),
      .wr      (bus_wr && rgn == RGN_W'(i + 1)),
      .woff    (widx),
      .wdata   (bus_wdata),
      .sts_clr (bus_wr && top_sel && widx == W_STS && bus_wdata[i]),
      .roff    (widx),
      .rdata   (ch_rdata[i]),
      .lvl     (ch_lvl[i]),
      .msg_en  (ch_msg[i]),
      .route   (ch_route[i]),
      .rt_data (ch_rtd[i]),
      .rt_addr (ch_rta[i]),
      .fire    (ch_fire[i]),
      .sts     (ch_sts[i])
    );
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (top_sel) begin
      case (widx)
        W_CAP: begin
          rd_mux[7:0]     = 8'(NCH - 1);
          rd_mux[CAP_LEG] = (NCH > 1);
        end
        W_PRD:   rd_mux = TICK_FS;
        W_GCFG: begin
          rd_mux[G_RUN] = run;
          rd_mux[G_LEG] = leg;
        end
        W_STS:   rd_mux[NCH-1:0] = ch_sts;
        W_CNTL:  rd_mux = cnt[DW-1:0];
        W_CNTH:  rd_mux = snap_hi;
        default: rd_mux = '0;
      endcase
    end
    for (int i = 0; i < NCH; i++)
      if (rgn == RGN_W'(i + 1)) rd_mux = ch_rdata[i];
  end

  logic [NLINES-1:0] irq_d;
  logic              tick_d, rtc_d, mv_d, line;
  logic [DW-1:0]     md_d, ma_d;
  always_comb begin
    irq_d  = '0;
    tick_d = 1'b0;
    rtc_d  = 1'b0;
    mv_d   = 1'b0;
    md_d   = '0;
    ma_d   = '0;
    line   = 1'b0;
    // descending so the lowest-numbered message channel wins
    for (int i = NCH - 1; i >= 0; i--) begin
      line = ch_lvl[i] ? ch_sts[i] : ch_fire[i];
      if (leg && i == 0)      tick_d = line;
      else if (leg && i == 1) rtc_d  = line;
      else if (ch_msg[i]) begin
        if (ch_fire[i]) begin
          mv_d = 1'b1;
          md_d = ch_rtd[i];
          ma_d = ch_rta[i];
        end
      end else irq_d[ch_route[i]] = irq_d[ch_route[i]] | line;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata   <= '0;
      irq_out     <= '0;
      legacy_tick <= 1'b0;
      legacy_rtc  <= 1'b0;
      msg_valid   <= 1'b0;
      msg_data    <= '0;
      msg_addr    <= '0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      irq_out     <= irq_d;
      legacy_tick <= tick_d;
      legacy_rtc  <= rtc_d;
      msg_valid   <= mv_d;
      msg_data    <= md_d;
      msg_addr    <= ma_d;
    end
  end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
  import evt_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NCH-1:0]    sts_wmask,
  input logic              run,
  input logic              leg,
  input logic [CW-1:0]     cnt,
  input logic [NCH-1:0]    ch_sts,
  input logic [NCH-1:0]    ch_fire,
  input logic              legacy_tick,
  input logic              legacy_rtc
);
  logic gsel, cnt_wr, sts_wr;
  assign gsel   = (bus_addr[ADDR_W-1:3] == '0);
  assign cnt_wr = bus_wr && gsel && (bus_addr[2:0] == W_CNTL || bus_addr[2:0] == W_CNTH);
  assign sts_wr = bus_wr && gsel && (bus_addr[2:0] == W_STS);

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_wr) |=> $stable(cnt)); // R2
  AST_RUN_STEP: assert property (@(posedge clk) disable iff (rst)
    run |=> (cnt == $past(cnt) + 64'd1)); // R2
  AST_LEGACY_OFF: assert property (@(posedge clk) disable iff (rst)
    !leg |=> (!legacy_tick && !legacy_rtc)); // R7

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    AST_LEVEL_STICKY: assert property (@(posedge clk) disable iff (rst)
      (ch_sts[i] && !(sts_wr && sts_wmask[i])) |=> ch_sts[i]); // R9
    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      ch_fire[i] |=> !ch_fire[i]); // R8
  end
endmodule

bind evt_timer evt_timer_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) i_evt_timer_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .sts_wmask   (bus_wdata[NCH-1:0]),
  .run         (run),
  .leg         (leg),
  .cnt         (cnt),
  .ch_sts      (ch_sts),
  .ch_fire     (ch_fire),
  .legacy_tick (legacy_tick),
  .legacy_rtc  (legacy_rtc)
);

// File: tb/test_evt_timer.sv
`timescale 1ns/1ps
module test_evt_timer;
  localparam logic [31:0] TICK = 32'd69841279;
  localparam logic [5:0] A_CAP = 6'd0, A_PRD = 6'd1, A_GCFG = 6'd2, A_STS = 6'd3,
                         A_CNTL = 6'd4, A_CNTH = 6'd5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [3:0]  irq_out;
  logic        legacy_tick, legacy_rtc, msg_valid;
  logic [31:0] msg_data, msg_addr;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  evt_timer #(.NCH(3), .NLINES(4), .ADDR_W(6), .TICK_FS(TICK)) i_evt_timer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out),
    .legacy_tick(legacy_tick), .legacy_rtc(legacy_rtc), .msg_valid(msg_valid),
    .msg_data(msg_data), .msg_addr(msg_addr));

  function automatic logic [5:0] chw(int ch, int off);
    return 6'(8 * (ch + 1) + off);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic sig(int w);
    case (w)
      4: return legacy_tick;
      5: return legacy_rtc;
      default: return irq_out[w];
    endcase
  endfunction

  task automatic wait_sig(input int w, input int max, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sig(w) && n < max);
  endtask

  task automatic t_regs();
    logic [31:0] v, a, b;
    do_reset();
    rd(A_CAP, v);  chk(v == 32'h8002, "R1 capability", v, 32'h8002);
    rd(A_PRD, v);  chk(v == TICK, "R1 period", v, TICK);
    wr(A_CAP, 32'h0); rd(A_CAP, v); chk(v == 32'h8002, "R1 capability write ignored", v, 32'h8002);
    rd(A_CNTL, v); chk(v == 0, "R2 counter reset", v, 0);
    wr(A_CNTL, 32'd5); rd(A_CNTL, v); chk(v == 5, "R2 stopped write low", v, 5);
    wr(A_CNTH, 32'd3); rd(A_CNTL, v); rd(A_CNTH, v); chk(v == 3, "R2 stopped write high", v, 3);
    wr(A_GCFG, 32'h1); wr(A_CNTL, 32'h0); rd(A_CNTL, v);
    chk(v > 5 && v < 25, "R2 running write ignored", v, 32'd7);
    wr(A_GCFG, 32'h0); rd(A_CNTL, a); repeat (10) @(negedge clk); rd(A_CNTL, b);
    chk(a == b, "R2 stopped holds", b, a);
  endtask

  task automatic t_tear();
    logic [31:0] v;
    do_reset();
    wr(A_CNTL, 32'hFFFF_FFF8); wr(A_CNTH, 32'h0); wr(A_GCFG, 32'h1);
    rd(A_CNTL, v); chk(v == 32'hFFFF_FFF8, "R3 low read", v, 32'hFFFF_FFF8);
    repeat (20) @(negedge clk);
    rd(A_CNTH, v); chk(v == 0, "R3 high from snapshot", v, 0);
    rd(A_CNTL, v); rd(A_CNTH, v); chk(v == 1, "R3 high after carry", v, 1);
  endtask

  task automatic t_oneshot();
    int n; bit seen;
    do_reset();
    wr(chw(0, 0), 32'h0000_0101); wr(chw(0, 2), 32'd10); wr(chw(0, 3), 32'd0);
    wr(chw(2, 2), 32'd5); wr(chw(2, 0), 32'h0000_0200);
    wr(A_GCFG, 32'h1);
    wait_sig(1, 100, n); chk(n == 12, "R4 match latency", n, 12);
    @(negedge clk); chk(irq_out[1] == 1'b0, "R8 single-cycle pulse", irq_out[1], 0);
    seen = 1'b0;
    repeat (40) begin @(negedge clk); if (irq_out[1] || irq_out[2]) seen = 1'b1; end
    chk(!seen, "R4 no refire and disabled channel silent", seen, 0);
  endtask

  task automatic t_periodic();
    logic [31:0] v; int n;
    do_reset();
    wr(chw(0, 0), 32'h0000_000F);
    wr(chw(0, 2), 32'd20);
    rd(chw(0, 2), v); chk(v == 20, "R5 immediate readback", v, 20);
    rd(chw(0, 0), v); chk(v[2] == 1'b0, "R5 set-value cleared", v[2], 0);
    chk(v == 32'h0000_C00B, "R5 config readback", v, 32'h0000_C00B);
    wr(chw(0, 2), 32'd7);
    rd(chw(0, 2), v); chk(v == 20, "R5 second write loads period", v, 20);
    wr(A_GCFG, 32'h1);
    wait_sig(0, 100, n); chk(n == 22, "R6 first periodic match", n, 22);
    wait_sig(0, 100, n); chk(n == 7, "R6 period spacing", n, 7);
    wait_sig(0, 100, n); chk(n == 7, "R6 period spacing again", n, 7);
  endtask

  task automatic t_legacy();
    int tk, rt, c; bit any;
    do_reset();
    wr(chw(0, 0), 32'h0000_0201); wr(chw(0, 2), 32'd5);
    wr(chw(1, 0), 32'h0000_0201); wr(chw(1, 2), 32'd8);
    wr(A_GCFG, 32'h3);
    tk = 0; rt = 0; c = 0; any = 1'b0;
    repeat (30) begin
      @(negedge clk); c++;
      if (legacy_tick && tk == 0) tk = c;
      if (legacy_rtc && rt == 0) rt = c;
      if (irq_out != 0) any = 1'b1;
    end
    chk(tk == 7, "R7 channel 0 on tick line", tk, 7);
    chk(rt == 10, "R7 channel 1 on rtc line", rt, 10);
    chk(!any, "R7 route field overridden", any, 0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    do_reset();
    wr(chw(2, 0), 32'h0000_0311); wr(chw(2, 2), 32'd4);
    wr(A_GCFG, 32'h1);
    repeat (20) @(negedge clk);
    chk(irq_out[3] == 1'b1, "R9 level held", irq_out[3], 1);
    rd(A_STS, v); chk(v == 4, "R9 status set", v, 4);
    wr(A_STS, 32'h0); rd(A_STS, v); chk(v == 4, "R9 zero write no effect", v, 4);
    chk(irq_out[3] == 1'b1, "R9 line still held", irq_out[3], 1);
    wr(A_STS, 32'h4); repeat (2) @(negedge clk);
    chk(irq_out[3] == 1'b0, "R9 line cleared", irq_out[3], 0);
    rd(A_STS, v); chk(v == 0, "R9 status cleared", v, 0);
  endtask

  task automatic t_msg();
    int n, c, pulses; bit any; logic [31:0] d, a;
    do_reset();
    wr(chw(1, 0), 32'h0000_0121); wr(chw(1, 4), 32'hCAFE_0001);
    wr(chw(1, 5), 32'h0FEE_0000); wr(chw(1, 2), 32'd6);
    wr(chw(2, 0), 32'h0000_0021); wr(chw(2, 4), 32'h0000_0002);
    wr(chw(2, 5), 32'h0000_0010); wr(chw(2, 2), 32'd6);
    wr(A_GCFG, 32'h1);
    n = 0; c = 0; pulses = 0; any = 1'b0; d = '0; a = '0;
    repeat (30) begin
      @(negedge clk); c++;
      if (msg_valid) begin
        pulses++;
        if (n == 0) begin n = c; d = msg_data; a = msg_addr; end
      end
      if (irq_out != 0) any = 1'b1;
    end
    chk(n == 8, "R10 message timing", n, 8);
    chk(d == 32'hCAFE_0001 && a == 32'h0FEE_0000, "R10 lowest channel payload", {d, a}, {32'hCAFE_0001, 32'h0FEE_0000});
    chk(pulses == 1, "R10 single request", pulses, 1);
    chk(!any, "R10 no line interrupt", any, 0);
  endtask

  task automatic t_mode32();
    int n, c; bit seen;
    do_reset();
    wr(A_CNTH, 32'h1);
    wr(chw(0, 0), 32'h0000_0009); wr(chw(0, 2), 32'd5); wr(chw(0, 3), 32'd7);
    wr(chw(1, 0), 32'h0000_0101); wr(chw(1, 2), 32'd5); wr(chw(1, 3), 32'd0);
    wr(A_GCFG, 32'h1);
    n = 0; c = 0; seen = 1'b0;
    repeat (40) begin
      @(negedge clk); c++;
      if (irq_out[0] && n == 0) n = c;
      if (irq_out[1]) seen = 1'b1;
    end
    chk(n == 7, "R11 32-bit match ignores high half", n, 7);
    chk(!seen, "R11 64-bit mode needs full match", seen, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_regs();
    t_tear();
    t_oneshot();
    t_periodic();
    t_legacy();
    t_level();
    t_msg();
    t_mode32();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule